// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit logical address into a physical address in two steps. First it checks the address against a small per-segment table. Then it reads one page table entry from memory. The logical address has three fields, from top to bottom: segment, page and offset. The segment field selects a table entry. That entry holds the physical base of the segment's page table, a bounds value (the number of valid entries) and read/write permissions.

When the page passes the bounds check and the segment's permission check, the block issues one memory read for the page table entry, using a valid/ready handshake. The physical address is then the entry's frame number placed in front of the untouched offset. There is no adder on the offset path. Any violation ends the translation with a fault code instead of an address.

The segment table is loaded through a separate configuration write port. That port is honoured only while the translator is idle.

Top module: `seg_page_xlate`

## Requirements
- R1: The logical address is split into three fields: segment = reqAddr[23:20], page = reqAddr[19:12], offset = reqAddr[11:0]. A successful translation returns physAddr = {frame, offset}, where frame is PTE bits [11:0].
- R2: The page table entry is read from memAddr = segment base + page × 4. memValid stays high and memAddr stays stable until memReady is seen. The entry is taken from memRdData in the cycle where memValid and memReady are both high.
- R3: A page number greater than or equal to the segment's bounds gives faultCode 1 and issues no memory read. A segment with bounds 0 faults on every page, and bounds 256 accepts page 255.
- R4: A write to a segment whose write permission is 0, or a read from a segment whose read permission is 0, gives faultCode 2 and issues no memory read. The bounds check takes precedence over this check.
- R5: A page table entry whose present bit (bit 31) is 0 gives faultCode 3. This fault takes precedence over the entry's permission bits.
- R6: For a present entry, a write when PTE bit 30 (write permission) is 0, or a read when PTE bit 29 (read permission) is 0, gives faultCode 2.
- R7: Every translation ends with doneValid high for exactly one cycle, carrying faultCode (0 none, 1 bounds, 2 protection, 3 not present). When faultCode is not 0, physAddr is 0.
- R8: A configuration write with cfgWrEn high updates the selected segment entry only when reqReady is high and reqValid is low. A write made while a translation is in progress is ignored.
- R9: After reset, reqReady is 1, and doneValid, memValid and physAddr are 0. Every segment has bounds 0 and no permissions, so any translation faults with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Translator idle and able to accept a request |
| reqAddr | input | 24 | Logical address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| doneValid | output | 1 | One-cycle completion pulse |
| physAddr | output | 24 | Translated physical address (0 on a fault) |
| faultCode | output | 2 | 0 none, 1 bounds, 2 protection, 3 not present |
| memValid | output | 1 | Page table read request |
| memReady | input | 1 | Memory accepts the read; memRdData is valid in this cycle |
| memAddr | output | 24 | Byte address of the page table entry |
| memRdData | input | 32 | Page table entry: [31] present, [30] W, [29] R, [11:0] frame |
| cfgWrEn | input | 1 | Segment table write strobe |
| cfgSeg | input | 4 | Segment entry to write |
| cfgBase | input | 24 | Physical base of that segment's page table |
| cfgBounds | input | 9 | Number of valid page table entries (0 to 256) |
| cfgRead | input | 1 | Segment read permission |
| cfgWrite | input | 1 | Segment write permission |

## Verification
The bench uses random segment tables and random page table contents to cover all fault branches. The bounds, segment permissions and the present and permission bits are all random, and memReady stalls at random. Among these patterns, a segment protection fault can be told apart from an entry protection fault only by whether a memory read took place.

Directed cases cover the bounds edges: bounds 0, page just below bounds and page equal to bounds, and bounds 256 with page 255. Another case uses an absent entry that also denies access, which shows whether the present check takes precedence. A configuration write issued in the middle of a translation must leave the following translation unchanged. A write issued while idle must change it.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef struct packed {
    logic accept;
    logic cfgApply;
    logic finishChk;
    logic loadPte;
    logic finishPte;
  } strobe_t;

  localparam int PTE_W         = 32;
  localparam int PTE_PRES_BIT  = 31;
  localparam int PTE_WR_BIT    = 30;
  localparam int PTE_RD_BIT    = 29;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cfgWrEn,
  input  logic    memReady,
  input  fault_e  chkFault,
  output logic    reqReady,
  output logic    memValid,
  output strobe_t strb
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FETCH, S_EVAL} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    reqReady  = (state == S_IDLE);
    memValid  = (state == S_FETCH);
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strb.accept = 1'b1;
          stateNext   = S_CHECK;
        end else if (cfgWrEn) begin
          strb.cfgApply = 1'b1;
        end
      end
      S_CHECK: begin
        if (chkFault != FLT_NONE) begin
          strb.finishChk = 1'b1;
          stateNext      = S_IDLE;
        end else begin
          stateNext = S_FETCH;
        end
      end
      S_FETCH: begin
        if (memReady) begin
          strb.loadPte = 1'b1;
          stateNext    = S_EVAL;
        end
      end
      default: begin
        strb.finishPte = 1'b1;
        stateNext      = S_IDLE;
      end
    endcase
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid) else $error("memValid dropped before memReady"); // R2

  AST_NO_CFG_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgApply |-> reqReady && !reqValid) else $error("config applied while busy"); // R8

endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12,
  localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int BND_W  = PAGE_W + 1,
  localparam int NSEG   = 1 << SEG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [VA_W-1:0]    reqAddr,
  input  logic               reqWrite,
  input  logic [SEG_W-1:0]   cfgSeg,
  input  logic [PA_W-1:0]    cfgBase,
  input  logic [BND_W-1:0]   cfgBounds,
  input  logic               cfgRead,
  input  logic               cfgWrite,
  input  logic [PTE_W-1:0]   memRdData,
  output fault_e             chkFault,
  output logic [PA_W-1:0]    memAddr,
  output logic               doneValid,
  output logic [PA_W-1:0]    physAddr,
  output logic [1:0]         faultCode
);

  logic [PA_W-1:0]  tabBase [NSEG];
  logic [BND_W-1:0] tabBnd  [NSEG];
  logic             tabRd   [NSEG];
  logic             tabWr   [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tabBase[g] <= '0;
        tabBnd[g]  <= '0;
        tabRd[g]   <= 1'b0;
        tabWr[g]   <= 1'b0;
      end else if (strb.cfgApply && cfgSeg == SEG_W'(g)) begin
        tabBase[g] <= cfgBase;
        tabBnd[g]  <= cfgBounds;
        tabRd[g]   <= cfgRead;
        tabWr[g]   <= cfgWrite;
      end
    end
  end

  logic [SEG_W-1:0]  segSel;
  logic [PAGE_W-1:0] pageReg;
  logic [OFF_W-1:0]  offReg;
  logic              wrReg;
  logic [PA_W-1:0]   curBase;
  logic [BND_W-1:0]  curBnd;
  logic              curRd, curWr;
  logic [PTE_W-1:0]  pteReg;
  fault_e            pteFault;

  assign segSel = reqAddr[VA_W-1 -: SEG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg <= '0;
      offReg  <= '0;
      wrReg   <= 1'b0;
      curBase <= '0;
      curBnd  <= '0;
      curRd   <= 1'b0;
      curWr   <= 1'b0;
    end else if (strb.accept) begin
      pageReg <= reqAddr[OFF_W +: PAGE_W];
      offReg  <= reqAddr[OFF_W-1:0];
      wrReg   <= reqWrite;
      curBase <= tabBase[segSel];
      curBnd  <= tabBnd[segSel];
      curRd   <= tabRd[segSel];
      curWr   <= tabWr[segSel];
    end
  end

  always_comb begin
    if ({1'b0, pageReg} >= curBnd)    chkFault = FLT_BOUNDS;
    else if (wrReg ? !curWr : !curRd) chkFault = FLT_PROT;
    else                              chkFault = FLT_NONE;
  end

  assign memAddr = curBase + {{(PA_W-PAGE_W-2){1'b0}}, pageReg, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN)             pteReg <= '0;
    else if (strb.loadPte) pteReg <= memRdData;
  end

  always_comb begin
    if (!pteReg[PTE_PRES_BIT])                                 pteFault = FLT_ABSENT;
    else if (wrReg ? !pteReg[PTE_WR_BIT] : !pteReg[PTE_RD_BIT]) pteFault = FLT_PROT;
    else                                                       pteFault = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      physAddr  <= '0;
      faultCode <= FLT_NONE;
    end else begin
      doneValid <= strb.finishChk | strb.finishPte;
      if (strb.finishChk) begin
        faultCode <= chkFault;
        physAddr  <= '0;
      end else if (strb.finishPte) begin
        faultCode <= pteFault;
        physAddr  <= (pteFault == FLT_NONE) ? {pteReg[FRAME_W-1:0], offReg} : '0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid) else $error("done longer than one cycle"); // R7

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && faultCode != FLT_NONE |-> physAddr == '0) else $error("address on fault"); // R7

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && faultCode == FLT_NONE |-> physAddr[OFF_W-1:0] == offReg) else $error("offset altered"); // R1

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> $stable(memAddr)) else $error("PTE address moved mid translation"); // R2

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12,
  localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int BND_W  = PAGE_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqAddr,
  input  logic               reqWrite,
  output logic               doneValid,
  output logic [PA_W-1:0]    physAddr,
  output logic [1:0]         faultCode,
  output logic               memValid,
  input  logic               memReady,
  output logic [PA_W-1:0]    memAddr,
  input  logic [PTE_W-1:0]   memRdData,
  input  logic               cfgWrEn,
  input  logic [SEG_W-1:0]   cfgSeg,
  input  logic [PA_W-1:0]    cfgBase,
  input  logic [BND_W-1:0]   cfgBounds,
  input  logic               cfgRead,
  input  logic               cfgWrite
);

  strobe_t strb;
  fault_e  chkFault;

  xlate_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWrEn  (cfgWrEn),
    .memReady (memReady),
    .chkFault (chkFault),
    .reqReady (reqReady),
    .memValid (memValid),
    .strb     (strb)
  );

  xlate_dpath #(
    .SEG_W   (SEG_W),
    .PAGE_W  (PAGE_W),
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .cfgSeg    (cfgSeg),
    .cfgBase   (cfgBase),
    .cfgBounds (cfgBounds),
    .cfgRead   (cfgRead),
    .cfgWrite  (cfgWrite),
    .memRdData (memRdData),
    .chkFault  (chkFault),
    .memAddr   (memAddr),
    .doneValid (doneValid),
    .physAddr  (physAddr),
    .faultCode (faultCode)
  );

endmodule

// File: tb/sim_seg_page_xlate.sv
module sim_seg_page_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        doneValid;
  logic [23:0] physAddr;
  logic [1:0]  faultCode;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [23:0] memAddr;
  logic [31:0] memRdData;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgSeg = '0;
  logic [23:0] cfgBase = '0;
  logic [8:0]  cfgBounds = '0;
  logic        cfgRead = 1'b0;
  logic        cfgWrite = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] memModel [1024];
  logic [23:0] tbBase [16];
  logic [8:0]  tbBnd  [16];
  logic        tbRd   [16];
  logic        tbWr   [16];

  always #2 clk = ~clk;

  assign memRdData = memModel[memAddr[11:2]];

  seg_page_xlate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .doneValid(doneValid),
    .physAddr(physAddr), .faultCode(faultCode), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memRdData(memRdData),
    .cfgWrEn(cfgWrEn), .cfgSeg(cfgSeg), .cfgBase(cfgBase),
    .cfgBounds(cfgBounds), .cfgRead(cfgRead), .cfgWrite(cfgWrite)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgWriteSeg(input int s, input logic [23:0] b, input logic [8:0] n,
                             input logic r, input logic w);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSeg = 4'(s); cfgBase = b; cfgBounds = n; cfgRead = r; cfgWrite = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
    tbBase[s] = b; tbBnd[s] = n; tbRd[s] = r; tbWr[s] = w;
  endtask

  // Expected outcome from the requirements: fault, address, whether a read happens
  function automatic void model(input logic [23:0] a, input logic wr,
                                output logic [1:0] f, output logic [23:0] pa,
                                output bit rd, output logic [23:0] ea);
    int s = int'(a[23:20]);
    logic [7:0] pg = a[19:12];
    logic [31:0] pte;
    ea = tbBase[s] + 24'(pg) * 24'd4;
    rd = 1'b0; pa = '0;
    if ({1'b0, pg} >= tbBnd[s])        f = 2'd1;
    else if (wr ? !tbWr[s] : !tbRd[s]) f = 2'd2;
    else begin
      rd  = 1'b1;
      pte = memModel[ea[11:2]];
      if (!pte[31])                    f = 2'd3;
      else if (wr ? !pte[30] : !pte[29]) f = 2'd2;
      else begin f = 2'd0; pa = {pte[11:0], a[11:0]}; end
    end
  endfunction

  task automatic translate(input logic [23:0] a, input logic wr, input bit midCfg,
                           output logic [1:0] f, output logic [23:0] pa,
                           output int nRd, output logic [23:0] seenAddr);
    int t = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    if (midCfg) begin
      cfgWrEn = 1'b1; cfgSeg = a[23:20]; cfgBase = 24'h0; cfgBounds = 9'd0;
      cfgRead = 1'b0; cfgWrite = 1'b0;
    end
    nRd = 0; seenAddr = '0;
    while (!doneValid && t < 200) begin
      if (memValid) begin nRd++; seenAddr = memAddr; end
      @(negedge clk);
      cfgWrEn = 1'b0;
      t++;
    end
    f = faultCode; pa = physAddr;
    check(t < 200, "R7", "done timeout", 32'(t), 32'd0);
    @(negedge clk);
    check(!doneValid, "R7", "done pulse width", 32'(doneValid), 32'd0);
  endtask

  task automatic runOne(input logic [23:0] a, input logic wr, input string tag);
    logic [1:0] f, ef; logic [23:0] pa, epa, ea, sa; bit rd; int n;
    model(a, wr, ef, epa, rd, ea);
    translate(a, wr, 1'b0, f, pa, n, sa);
    check(f == ef, tag, "faultCode", 32'(f), 32'(ef));
    check(pa == epa, (ef == 0) ? "R1" : "R7", "physAddr", 32'(pa), 32'(epa));
    if (rd) check(n > 0 && sa == ea, "R2", "PTE read address", 32'(sa), 32'(ea));
    else    check(n == 0, (ef == 1) ? "R3" : "R4", "no memory read", 32'(n), 32'd0);
  endtask

  function automatic string tagFor(input logic [23:0] a, input logic wr);
    logic [1:0] f; logic [23:0] pa, ea; bit rd;
    model(a, wr, f, pa, rd, ea);
    case (f)
      2'd0: return "R1";
      2'd1: return "R3";
      2'd2: return rd ? "R6" : "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) memModel[i] = $urandom;
    for (int s = 0; s < 16; s++) begin tbBase[s] = '0; tbBnd[s] = '0; tbRd[s] = 0; tbWr[s] = 0; end
  end

  always @(negedge clk) if (rstN) memReady <= ($urandom % 3) != 0;

  initial begin
    logic [1:0] f; logic [23:0] pa, sa; int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(reqReady == 1'b1, "R9", "reqReady after reset", 32'(reqReady), 32'd1);
    check(!doneValid && !memValid, "R9", "done/mem idle", {30'd0, doneValid, memValid}, 32'd0);
    check(physAddr == 0, "R9", "physAddr after reset", 32'(physAddr), 32'd0);
    runOne(24'h5_12_345, 1'b0, "R9");

    // R3 bounds edges
    cfgWriteSeg(2, 24'h000400, 9'd13, 1'b1, 1'b1);
    memModel[(24'h400 + 12*4) >> 2] = 32'hE000_0ABC;
    runOne(24'h2_0C_777, 1'b0, "R3");
    runOne(24'h2_0D_777, 1'b0, "R3");
    cfgWriteSeg(3, 24'h000000, 9'd256, 1'b1, 1'b0);
    memModel[255] = 32'hA000_0123;
    runOne(24'h3_FF_001, 1'b0, "R3");
    runOne(24'h3_FF_001, 1'b1, "R4");
    cfgWriteSeg(4, 24'h000800, 9'd0, 1'b1, 1'b1);
    runOne(24'h4_00_000, 1'b0, "R3");

    // R5 precedence: absent entry that also denies access
    cfgWriteSeg(5, 24'h000C00, 9'd4, 1'b1, 1'b1);
    memModel[(24'hC00 >> 2) + 1] = 32'h0000_0055;
    runOne(24'h5_01_010, 1'b1, "R5");
    // R6 present but write-protected
    memModel[(24'hC00 >> 2) + 2] = 32'hA000_0066;
    runOne(24'h5_02_020, 1'b1, "R6");
    runOne(24'h5_02_020, 1'b0, "R1");

    // R8 config write during a translation is ignored
    memModel[(24'hC00 >> 2) + 3] = 32'hE000_0077;
    translate(24'h5_03_abc, 1'b0, 1'b1, f, pa, n, sa);
    check(f == 0, "R8", "fault during cfg-busy", 32'(f), 32'd0);
    runOne(24'h5_03_abc, 1'b0, "R8");
    cfgWriteSeg(5, 24'h000C00, 9'd3, 1'b1, 1'b1);
    runOne(24'h5_03_abc, 1'b0, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a; logic wr;
      if (i % 40 == 0)
        for (int s = 0; s < 16; s++)
          cfgWriteSeg(s, 24'(($urandom % 768) * 4),
                      ($urandom % 4 == 0) ? 9'($urandom % 257) : 9'(128 + $urandom % 129),
                      1'($urandom % 5 != 0), 1'($urandom % 3 != 0));
      a = 24'($urandom); wr = 1'($urandom);
      runOne(a, wr, tagFor(a, wr));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule